// File: doc/BRIEF.md
# Jittered Foldback Switching Oscillator

This block sets the switching cadence for a peak-current-mode converter. A digitized feedback-level code arrives every clock. The block turns that code into a switching period, counted in clock cycles. At high feedback the period is the nominal one. Inside a foldback band the period stretches linearly toward a floor value, which lowers the switching frequency at light load. Below a lower threshold the block stops issuing cycles altogether, with hysteresis on that decision.

A slow triangular dither is added to the period in every region, so the spectral energy of the switching spreads out. The block produces three outputs: a one-clock cycle-start strobe, a one-clock strobe that ends the on-time at 80% of the period, and a level that shows when cycles are being skipped. While cycles are skipped the period counter keeps running, so a restart always falls on a period boundary.

Top module: `jitter_fold_osc`

## Requirements
- R1: While reset is asserted, cyc_start, duty_end and skip are low. With feedback at or above FOLD_HI, the first cyc_start comes on the NOM-th rising edge after reset is released, where NOM = CLK_KHZ/65, or CLK_KHZ/100 when FAST=1.
- R2: If the code sampled at a period boundary is at or above FOLD_HI, the next period is NOM plus the current dither value, counted in clock cycles.
- R3: If the code f lies strictly between FOLD_LO and FOLD_HI, the base period is MAXP - floor((f-FOLD_LO)*S/256), where S = floor((MAXP-NOM)*256/(FOLD_HI-FOLD_LO)).
- R4: If the code is at or below FOLD_LO, the base period is MAXP = CLK_KHZ/26.
- R5: The dither value starts at 0 and counts upward. It moves by one step every DIV clocks and reverses direction on reaching +AMP or -AMP. AMP = floor(NOM*DITH_PCT/100) and DIV = floor(CLK_KHZ*1000/(DITH_HZ*4*AMP)). The dither applies in all regions.
- R6: The period and the duty point are sampled only at a period boundary. Changes in the code during a period do not alter the period in progress.
- R7: duty_end pulses on the clock where the count since cyc_start equals floor(P*DUTY_PCT/100), where P is the current period.
- R8: When skip is low and the code is below SKIP_ON, skip goes high on the next clock.
- R9: When skip is high, it goes low on the next clock once the code is at or above SKIP_ON+SKIP_HYST. Inside the band between SKIP_ON and that value, skip holds.
- R10: A period that begins while skip is high has neither a cyc_start nor a duty_end. The period counter keeps running through skipped periods.
- R11: Each strobe is one clock wide, and the two strobes never occur on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_code | input | FB_W | Digitized feedback level |
| cyc_start | output | 1 | One-clock strobe at the start of a switching cycle |
| duty_end | output | 1 | One-clock strobe at the maximum on-time point |
| skip | output | 1 | High while cycles are being skipped |

## Verification
The bench builds the block with CLK_KHZ=2600. This gives a nominal period of 40 clocks, a floor of 100 clocks, a dither amplitude of 2 and a dither step every 1354 clocks. With these values a full dither sweep takes under 11,000 clocks, so both dither extremes appear in the measured periods, and each foldback and skip region can be covered within a few hundred periods. The code scale and thresholds are left at their defaults, so the measured curve is the same one used in a full-rate build. One stretch of stimulus toggles the code faster than a period, to show that changes only take effect at a boundary. Another crosses the skip band in both directions.

// File: rtl/osc_pkg.sv
package osc_pkg;
    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dith_dir_e;

    localparam int SLOPE_FRAC = 8;
endpackage

// File: rtl/osc_fold_map.sv
module osc_fold_map #(
    parameter int FB_W  = 8,
    parameter int NOM   = 1538,
    parameter int MAXP  = 3846,
    parameter int HI    = 94,
    parameter int LO    = 22,
    parameter int PER_W = 12
) (
    input  logic [FB_W-1:0]  fb,
    output logic [PER_W-1:0] base
);
    localparam int SPAN  = HI - LO;
    localparam int SLOPE = ((MAXP - NOM) << osc_pkg::SLOPE_FRAC) / SPAN;

    logic [31:0] offs;
    logic [31:0] prod;
    logic [31:0] fold;

    always_comb begin
        offs = 32'(fb) - 32'(LO);
        prod = offs * 32'(SLOPE);
        fold = 32'(MAXP) - (prod >> osc_pkg::SLOPE_FRAC);
        if (fb >= FB_W'(HI)) begin
            base = PER_W'(NOM);
        end else if (fb <= FB_W'(LO)) begin
            base = PER_W'(MAXP);
        end else begin
            base = fold[PER_W-1:0];
        end
    end
endmodule

// File: rtl/osc_dither.sv
module osc_dither #(
    parameter int AMP = 76,
    parameter int DIV = 1370,
    parameter int DW  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic signed [DW-1:0] dith
);
    generate
        if (AMP == 0) begin : g_flat
            assign dith = '0;
        end else begin : g_tri
            localparam int PREW = $clog2(DIV + 1);

            typedef struct packed {
                logic [PREW-1:0]     pre;
                logic [DW-1:0]       val;
                osc_pkg::dith_dir_e  dir;
            } dst_t;

            dst_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (st_q.pre == PREW'(DIV - 1)) begin
                    st_d.pre = '0;
                    if (st_q.dir == osc_pkg::DIR_UP) begin
                        if (st_q.val == DW'(AMP)) begin
                            st_d.dir = osc_pkg::DIR_DN;
                            st_d.val = st_q.val - DW'(1);
                        end else begin
                            st_d.val = st_q.val + DW'(1);
                        end
                    end else begin
                        if (st_q.val == (~DW'(AMP) + DW'(1))) begin
                            st_d.dir = osc_pkg::DIR_UP;
                            st_d.val = st_q.val + DW'(1);
                        end else begin
                            st_d.val = st_q.val - DW'(1);
                        end
                    end
                end else begin
                    st_d.pre = st_q.pre + PREW'(1);
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q.pre <= '0;
                    st_q.val <= '0;
                    st_q.dir <= osc_pkg::DIR_UP;
                end else begin
                    st_q <= st_d;
                end
            end

            assign dith = $signed(st_q.val);
        end
    endgenerate
endmodule

// File: rtl/osc_skip_hyst.sv
module osc_skip_hyst #(
    parameter int FB_W = 8,
    parameter int ON   = 19,
    parameter int OFF  = 21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FB_W-1:0] fb,
    output logic            skip_d,
    output logic            skip_q
);
    always_comb begin
        skip_d = skip_q;
        if (skip_q && (fb >= FB_W'(OFF))) begin
            skip_d = 1'b0;
        end else if (!skip_q && (fb < FB_W'(ON))) begin
            skip_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_q <= 1'b0;
        end else begin
            skip_q <= skip_d;
        end
    end
endmodule

// File: rtl/jitter_fold_osc.sv
module jitter_fold_osc #(
    parameter int CLK_KHZ   = 100000,
    parameter int FAST      = 0,
    parameter int DUTY_PCT  = 80,
    parameter int DITH_PCT  = 5,
    parameter int DITH_HZ   = 240,
    parameter int FB_W      = 8,
    parameter int FOLD_HI   = 94,
    parameter int FOLD_LO   = 22,
    parameter int SKIP_ON   = 19,
    parameter int SKIP_HYST = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FB_W-1:0] fb_code,
    output logic            cyc_start,
    output logic            duty_end,
    output logic            skip
);
    localparam int NOM    = (FAST != 0) ? (CLK_KHZ / 100) : (CLK_KHZ / 65);
    localparam int MAXP   = CLK_KHZ / 26;
    localparam int AMP    = (NOM * DITH_PCT) / 100;
    localparam int DIV_R  = (AMP == 0) ? 1 : (CLK_KHZ * 1000) / (DITH_HZ * 4 * AMP);
    localparam int DIV    = (DIV_R < 1) ? 1 : DIV_R;
    localparam int PER_W  = $clog2(MAXP + AMP + 1);
    localparam int DW     = $clog2(AMP + 1) + 1;
    localparam int PROD_W = PER_W + 8;
    localparam int SKIP_OFF = SKIP_ON + SKIP_HYST;

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] per;
        logic [PER_W-1:0] duty;
        logic             act;
    } ost_t;

    ost_t st_d, st_q;

    logic [PER_W-1:0]        base;
    logic signed [DW-1:0]    dith;
    logic                    skip_nxt;
    logic                    skip_reg;
    logic                    wrap;
    logic signed [PER_W+1:0] psum;
    logic [PROD_W-1:0]       dprod;

    osc_fold_map #(
        .FB_W (FB_W),
        .NOM  (NOM),
        .MAXP (MAXP),
        .HI   (FOLD_HI),
        .LO   (FOLD_LO),
        .PER_W(PER_W)
    ) map_i (
        .fb  (fb_code),
        .base(base)
    );

    osc_dither #(
        .AMP(AMP),
        .DIV(DIV),
        .DW (DW)
    ) dith_i (
        .clk  (clk),
        .rst_n(rst_n),
        .dith (dith)
    );

    osc_skip_hyst #(
        .FB_W(FB_W),
        .ON  (SKIP_ON),
        .OFF (SKIP_OFF)
    ) skip_i (
        .clk   (clk),
        .rst_n (rst_n),
        .fb    (fb_code),
        .skip_d(skip_nxt),
        .skip_q(skip_reg)
    );

    always_comb begin
        st_d  = st_q;
        wrap  = (st_q.cnt == (st_q.per - PER_W'(1)));
        psum  = $signed({2'b00, base}) + (PER_W + 2)'(dith);
        dprod = PROD_W'(psum[PER_W-1:0]) * PROD_W'(DUTY_PCT);
        if (wrap) begin
            st_d.cnt  = '0;
            st_d.per  = psum[PER_W-1:0];
            st_d.duty = PER_W'(dprod / PROD_W'(100));
            st_d.act  = !skip_nxt;
        end else begin
            st_d.cnt  = st_q.cnt + PER_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.per  <= PER_W'(NOM);
            st_q.duty <= PER_W'((NOM * DUTY_PCT) / 100);
            st_q.act  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cyc_start = st_q.act && (st_q.cnt == '0);
    assign duty_end  = st_q.act && (st_q.cnt == st_q.duty);
    assign skip      = skip_reg;
endmodule

// File: rtl/jitter_fold_osc_chk.sv
module jitter_fold_osc_chk #(
    parameter int FB_W     = 8,
    parameter int SKIP_ON  = 19,
    parameter int SKIP_OFF = 21
) (
    input logic            clk,
    input logic            rst_n,
    input logic [FB_W-1:0] fb_code,
    input logic            cyc_start,
    input logic            duty_end,
    input logic            skip
);
    AST_START_NOT_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |-> !skip); // R10
    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_start && duty_end)); // R11
    AST_START_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> !cyc_start); // R11
    AST_SKIP_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (!skip && (fb_code < FB_W'(SKIP_ON))) |=> skip); // R8
    AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (skip && (fb_code < FB_W'(SKIP_OFF))) |=> skip); // R9
    AST_SKIP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (skip && (fb_code >= FB_W'(SKIP_OFF))) |=> !skip); // R9
endmodule

bind jitter_fold_osc jitter_fold_osc_chk #(
    .FB_W    (FB_W),
    .SKIP_ON (SKIP_ON),
    .SKIP_OFF(SKIP_ON + SKIP_HYST)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fb_code  (fb_code),
    .cyc_start(cyc_start),
    .duty_end (duty_end),
    .skip     (skip)
);

// File: tb/jitter_fold_osc_tb_top.sv
`timescale 1ns/1ps
module jitter_fold_osc_tb_top;
    localparam int CLK_KHZ = 2600;
    localparam int PCT     = 80;
    localparam int HI      = 94;
    localparam int LO      = 22;
    localparam int S_ON    = 19;
    localparam int S_OFF   = 21;
    localparam int NOM     = CLK_KHZ / 65;
    localparam int MAXP    = CLK_KHZ / 26;
    localparam int AMP     = NOM * 5 / 100;
    localparam int DIV     = CLK_KHZ * 1000 / (240 * 4 * AMP);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] fb = 8'd200;
    logic       cyc_start, duty_end, skip;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    string req = "R1";
    bit meas_on = 0;
    int last_start = -1;
    int ivals[$];

    int m_cnt, m_per, m_duty, m_act, m_skip, m_dith, m_up, m_pre;

    always #2 clk = ~clk;

    jitter_fold_osc #(.CLK_KHZ(CLK_KHZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .fb_code(fb),
        .cyc_start(cyc_start), .duty_end(duty_end), .skip(skip)
    );

    function automatic int base_of(int f);
        int s;
        if (f >= HI) return NOM;
        if (f <= LO) return MAXP;
        s = ((MAXP - NOM) * 256) / (HI - LO);
        return MAXP - ((f - LO) * s) / 256;
    endfunction

    task automatic chk(bit ok, string r, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", r, what, act, exp, cyc);
        end
    endtask

    // behavioural reference, advanced once per rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_per = NOM; m_duty = NOM * PCT / 100; m_act = 0;
            m_skip = 0; m_dith = 0; m_up = 1; m_pre = 0;
        end else begin
            int sk;
            sk = m_skip;
            if (m_skip != 0 && fb >= S_OFF) sk = 0;
            else if (m_skip == 0 && fb < S_ON) sk = 1;
            if (m_cnt == m_per - 1) begin
                m_cnt = 0;
                m_per = base_of(fb) + m_dith;
                m_duty = m_per * PCT / 100;
                m_act = (sk == 0);
            end else begin
                m_cnt++;
            end
            m_skip = sk;
            if (m_pre == DIV - 1) begin
                m_pre = 0;
                if (m_up != 0) begin
                    if (m_dith == AMP) begin m_up = 0; m_dith--; end
                    else m_dith++;
                end else begin
                    if (m_dith == -AMP) begin m_up = 1; m_dith++; end
                    else m_dith--;
                end
            end else begin
                m_pre++;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done && cyc > 0) begin
            bit es, ed;
            es = (m_act != 0) && (m_cnt == 0);
            ed = (m_act != 0) && (m_cnt == m_duty);
            chk(cyc_start == es, req, "cyc_start", cyc_start, es);
            chk(duty_end == ed, "R7", "duty_end", duty_end, ed);
            chk(skip == (m_skip != 0), "R8", "skip", skip, m_skip);
            chk(!(cyc_start && duty_end), "R11", "overlap", 1, 0);
            if (cyc_start) begin
                if (meas_on && last_start >= 0) ivals.push_back(cyc - last_start);
                last_start = cyc;
            end
        end
    end

    task automatic run(int f, int n, string r);
        @(negedge clk);
        fb = f;
        req = r;
        repeat (n) @(negedge clk);
    endtask

    task automatic meas(bit on);
        meas_on = on;
        last_start = -1;
        if (on) ivals.delete();
    endtask

    initial begin
        int mn, mx, nst;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(cyc_start == 0 && duty_end == 0 && skip == 0, "R1", "reset outputs",
            {cyc_start, duty_end, skip}, 0);
        meas(1);
        rst_n = 1'b1;
        repeat (NOM - 1) @(posedge clk);
        @(negedge clk);
        chk(cyc_start == 0, "R1", "no start before NOM edges", cyc_start, 0);
        @(posedge clk);
        @(negedge clk);
        chk(cyc_start == 1, "R1", "first start at NOM edges", cyc_start, 1);
        // R2 and R5: nominal region, one full dither sweep
        run(200, 12000, "R2");
        mn = 1 << 30; mx = 0;
        foreach (ivals[i]) begin
            if (ivals[i] < mn) mn = ivals[i];
            if (ivals[i] > mx) mx = ivals[i];
        end
        chk(mn == NOM - AMP, "R5", "shortest period", mn, NOM - AMP);
        chk(mx == NOM + AMP, "R5", "longest period", mx, NOM + AMP);
        meas(0);
        run(60, 1500, "R3");
        run(94, 500, "R2");
        run(93, 500, "R3");
        run(22, 300, "R4");
        meas(1);
        run(22, 1500, "R4");
        mn = 1 << 30; mx = 0;
        foreach (ivals[i]) begin
            if (ivals[i] < mn) mn = ivals[i];
            if (ivals[i] > mx) mx = ivals[i];
        end
        chk(ivals.size() > 0 && mn >= MAXP - AMP && mx <= MAXP + AMP, "R4",
            "floor period range", mx, MAXP);
        meas(0);
        run(21, 500, "R4");
        // R8 entry, R9 hold and exit, R10 suppression
        @(negedge clk); fb = 18; req = "R10";
        @(negedge clk);
        chk(skip == 1, "R8", "skip raised next clock", skip, 1);
        repeat (300) @(negedge clk);
        meas(1);
        run(20, 600, "R10");
        nst = ivals.size();
        chk(skip == 1, "R9", "skip held in band", skip, 1);
        chk(nst == 0 && last_start < 0, "R10", "no start while skipping", last_start, -1);
        meas(0);
        run(21, 1, "R9");
        chk(skip == 0, "R9", "skip cleared at exit level", skip, 0);
        run(21, 600, "R9");
        run(5, 400, "R10");
        run(120, 400, "R2");
        // R6: code toggles faster than a period
        for (int k = 0; k < 80; k++) begin
            run((k % 2 == 0) ? 40 : 150, 13, "R6");
        end
        // thresholds crossed quickly in both directions
        for (int k = 0; k < 60; k++) begin
            run((k % 3 == 0) ? 18 : ((k % 3 == 1) ? 20 : 30), 7, "R9");
        end
        run(0, 400, "R10");
        run(200, 600, "R2");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule